// File: doc/BRIEF.md
# Indexed configuration register port

This block holds a bank of processor configuration registers behind two I/O addresses. Software writes an 8-bit register index to the index port. It then makes one read or one write at the data port. For each data-port access the block decides in the same cycle whether the access belongs to it. When it does not, it raises `extCycle` so that the surrounding bus logic forwards the access as an external I/O cycle.

Two bits in the register at index C3h set the rules. The wide-map bit (bit 4) opens a second group of indices outside the C0h–CFh window. The lock bit (bit 0) write-protects a few system-management registers. While the lock is set, only code running with `smmActive` high can change them. Two read-only identification registers sit at FEh and FFh. The stored values only configure logic elsewhere; this block does not interpret them.

Top module: `cfg_idx_port`

## Requirements
- R1: A write to the index port (default 22h) stores the byte as the current index and arms exactly one data-port access. An index-port write never raises `extCycle`.
- R2: Every data-port access (default 23h), claimed or not, uses up the armed index. A data-port access with no armed index raises `extCycle`, reads FFh and changes no register.
- R3: With the wide-map bit clear, the only indices claimed are C1h, C2h, C3h, CDh–CFh, FEh and FFh. Accesses to any other index are external.
- R4: With bit 4 of the register at C3h set, indices E8h, EBh, 20h, B0h–B3h, B8h, B9h and BAh–BDh are also claimed and store what is written.
- R5: After reset, E8h reads 85h and 20h reads 07h. FEh reads 4h in its upper nibble with a parameter in the lower nibble. Every other writable register, B0h–B3h included, reads 00h.
- R6: While bit 0 of C3h is set and `smmActive` is low, writes to C1h, C3h and CDh–CFh are claimed (`extCycle` low) but ignored. With `smmActive` high they take effect.
- R7: Bit 0 of C3h, once set, stays set until reset. A write that clears it leaves it at 1 and still updates the other bits.
- R8: FEh and FFh are read-only. Writes to them are claimed and have no effect. FFh reads a parameter value.
- R9: An unclaimed data access, including an unimplemented index inside C0h–CFh, drives `extCycle` high during the strobe cycle, and a read returns FFh. A claimed read returns the stored value in the same cycle. A claimed write takes effect at the clock edge that ends the strobe.
- R10: A read of the index port raises `extCycle`. Accesses to any address other than the two ports leave `extCycle` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | ADDR_W | I/O address of the current access |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioWdata | input | 8 | Write data |
| smmActive | input | 1 | High while system-management code runs; lifts the lock |
| ioRdata | output | 8 | Read data for a claimed data read, FFh otherwise |
| extCycle | output | 1 | High when the current access must go out as an external cycle |

## Verification
The bench makes a data access right after an unclaimed one. A design that consumed the index only on claimed accesses would wrongly claim that second access. It tries to clear the lock bit from system-management mode, which catches a lock that can be cleared by software. It writes to the identification registers and to locked registers and then reads them back, so a design that stored those writes shows changed values. It also probes wide-map indices before and after the bit flips and an unimplemented index inside C0h–CFh. An incorrect window decode would claim those accesses or send them out.

// File: rtl/cfg_idx_pkg.sv
package cfg_idx_pkg;

  localparam int DATA_W   = 8;
  localparam int MAP_BIT  = 4;   // wide-map enable inside the C3h register
  localparam int LOCK_BIT = 0;   // sticky lock inside the C3h register
  localparam int HDR_N    = 4;
  localparam int MASK_N   = 4;
  localparam int SADDR_N  = 3;

  localparam logic [DATA_W-1:0] IDX_CTL1  = 8'hC1;
  localparam logic [DATA_W-1:0] IDX_CTL2  = 8'hC2;
  localparam logic [DATA_W-1:0] IDX_CTL3  = 8'hC3;
  localparam logic [DATA_W-1:0] IDX_CTL4  = 8'hE8;
  localparam logic [DATA_W-1:0] IDX_CTL7  = 8'hEB;
  localparam logic [DATA_W-1:0] IDX_PERF  = 8'h20;
  localparam logic [DATA_W-1:0] IDX_HDR   = 8'hB0;
  localparam logic [DATA_W-1:0] IDX_GFX   = 8'hB8;
  localparam logic [DATA_W-1:0] IDX_VID   = 8'hB9;
  localparam logic [DATA_W-1:0] IDX_MASK  = 8'hBA;
  localparam logic [DATA_W-1:0] IDX_SADDR = 8'hCD;
  localparam logic [DATA_W-1:0] IDX_ID0   = 8'hFE;
  localparam logic [DATA_W-1:0] IDX_ID1   = 8'hFF;

  localparam logic [DATA_W-1:0] RST_CTL4  = 8'h85;
  localparam logic [DATA_W-1:0] RST_PERF  = 8'h07;
  localparam logic [DATA_W-1:0] IDLE_DATA = 8'hFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTL1, SEL_CTL2, SEL_CTL3, SEL_CTL4, SEL_CTL7, SEL_PERF,
    SEL_HDR, SEL_GFX, SEL_VID, SEL_MASK, SEL_SADDR, SEL_ID0, SEL_ID1
  } reg_sel_e;

  typedef struct packed {
    logic              rdEn;
    logic              wrEn;
    logic [DATA_W-1:0] idx;
    reg_sel_e          sel;
  } port_strb_t;

  function automatic reg_sel_e decodeIdx(input logic [DATA_W-1:0] idx);
    reg_sel_e s;
    s = SEL_NONE;
    if (idx == IDX_CTL1)                                       s = SEL_CTL1;
    else if (idx == IDX_CTL2)                                  s = SEL_CTL2;
    else if (idx == IDX_CTL3)                                  s = SEL_CTL3;
    else if (idx == IDX_CTL4)                                  s = SEL_CTL4;
    else if (idx == IDX_CTL7)                                  s = SEL_CTL7;
    else if (idx == IDX_PERF)                                  s = SEL_PERF;
    else if (idx >= IDX_HDR && idx < IDX_HDR + 8'(HDR_N))      s = SEL_HDR;
    else if (idx == IDX_GFX)                                   s = SEL_GFX;
    else if (idx == IDX_VID)                                   s = SEL_VID;
    else if (idx >= IDX_MASK && idx < IDX_MASK + 8'(MASK_N))   s = SEL_MASK;
    else if (idx >= IDX_SADDR && idx < IDX_SADDR + 8'(SADDR_N)) s = SEL_SADDR;
    else if (idx == IDX_ID0)                                   s = SEL_ID0;
    else if (idx == IDX_ID1)                                   s = SEL_ID1;
    return s;
  endfunction

  function automatic logic inBaseWindow(input logic [DATA_W-1:0] idx);
    return (idx[7:4] == 4'hC) || (idx == IDX_ID0) || (idx == IDX_ID1);
  endfunction

  function automatic logic lockCovered(input reg_sel_e sel);
    return (sel == SEL_CTL1) || (sel == SEL_CTL3) || (sel == SEL_SADDR);
  endfunction

endpackage

// File: rtl/cfg_idx_ctrl.sv
module cfg_idx_ctrl
  import cfg_idx_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0023
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic              smmActive,
  input  logic              wideMap,
  input  logic              smmLock,
  output port_strb_t        strb,
  output logic              extCycle
);

  logic [DATA_W-1:0] idxQ;
  logic              idxValid;
  logic              atIdx, atData, dataAcc;
  reg_sel_e          curSel;
  logic              claim, blocked, readOnly;

  assign atIdx   = (ioAddr == IDX_PORT);
  assign atData  = (ioAddr == DATA_PORT);
  assign dataAcc = atData && (ioRd || ioWr);

  // index register, armed by the index port, consumed by any data access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ     <= '0;
      idxValid <= 1'b0;
    end else if (atIdx && ioWr) begin
      idxQ     <= ioWdata;
      idxValid <= 1'b1;
    end else if (dataAcc) begin
      idxValid <= 1'b0;
    end
  end

  always_comb begin
    curSel   = decodeIdx(idxQ);
    claim    = idxValid && (curSel != SEL_NONE) && (wideMap || inBaseWindow(idxQ));
    blocked  = smmLock && !smmActive && lockCovered(curSel);
    readOnly = (curSel == SEL_ID0) || (curSel == SEL_ID1);

    strb.rdEn = dataAcc && ioRd && claim;
    strb.wrEn = atData && ioWr && claim && !blocked && !readOnly;
    strb.idx  = idxQ;
    strb.sel  = curSel;

    extCycle  = (dataAcc && !claim) || (atIdx && ioRd);
  end

endmodule

// File: rtl/cfg_idx_regs.sv
module cfg_idx_regs
  import cfg_idx_pkg::*;
#(
  parameter logic [3:0]        ID0_LO  = 4'h1,
  parameter logic [DATA_W-1:0] ID1_VAL = 8'h25
) (
  input  logic              clk,
  input  logic              rstN,
  input  port_strb_t        strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdVal,
  output logic              wideMap,
  output logic              smmLock
);

  localparam logic [DATA_W-1:0] ID0_VAL = {4'h4, ID0_LO};

  logic [DATA_W-1:0] ctl1, ctl2, ctl3, ctl4, ctl7, perf, gfx, vidCtl;
  logic [DATA_W-1:0] smmHdr  [HDR_N];
  logic [DATA_W-1:0] vidMask [MASK_N];
  logic [DATA_W-1:0] smmAddr [SADDR_N];
  logic [DATA_W-1:0] hdrOff, maskOff, saOff, ctl3Next;

  assign hdrOff  = strb.idx - IDX_HDR;
  assign maskOff = strb.idx - IDX_MASK;
  assign saOff   = strb.idx - IDX_SADDR;

  assign wideMap = ctl3[MAP_BIT];
  assign smmLock = ctl3[LOCK_BIT];

  // lock bit only ever sets until reset
  always_comb begin
    ctl3Next           = wdata;
    ctl3Next[LOCK_BIT] = wdata[LOCK_BIT] | ctl3[LOCK_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl1   <= '0;
      ctl2   <= '0;
      ctl3   <= '0;
      ctl4   <= RST_CTL4;
      ctl7   <= '0;
      perf   <= RST_PERF;
      gfx    <= '0;
      vidCtl <= '0;
      for (int i = 0; i < HDR_N; i++)   smmHdr[i]  <= '0;
      for (int i = 0; i < MASK_N; i++)  vidMask[i] <= '0;
      for (int i = 0; i < SADDR_N; i++) smmAddr[i] <= '0;
    end else if (strb.wrEn) begin
      unique case (strb.sel)
        SEL_CTL1: ctl1   <= wdata;
        SEL_CTL2: ctl2   <= wdata;
        SEL_CTL3: ctl3   <= ctl3Next;
        SEL_CTL4: ctl4   <= wdata;
        SEL_CTL7: ctl7   <= wdata;
        SEL_PERF: perf   <= wdata;
        SEL_GFX:  gfx    <= wdata;
        SEL_VID:  vidCtl <= wdata;
        SEL_HDR:
          for (int i = 0; i < HDR_N; i++)
            if (hdrOff == 8'(i)) smmHdr[i] <= wdata;
        SEL_MASK:
          for (int i = 0; i < MASK_N; i++)
            if (maskOff == 8'(i)) vidMask[i] <= wdata;
        SEL_SADDR:
          for (int i = 0; i < SADDR_N; i++)
            if (saOff == 8'(i)) smmAddr[i] <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdVal = IDLE_DATA;
    if (strb.rdEn) begin
      unique case (strb.sel)
        SEL_CTL1: rdVal = ctl1;
        SEL_CTL2: rdVal = ctl2;
        SEL_CTL3: rdVal = ctl3;
        SEL_CTL4: rdVal = ctl4;
        SEL_CTL7: rdVal = ctl7;
        SEL_PERF: rdVal = perf;
        SEL_GFX:  rdVal = gfx;
        SEL_VID:  rdVal = vidCtl;
        SEL_ID0:  rdVal = ID0_VAL;
        SEL_ID1:  rdVal = ID1_VAL;
        SEL_HDR:
          for (int i = 0; i < HDR_N; i++)
            if (hdrOff == 8'(i)) rdVal = smmHdr[i];
        SEL_MASK:
          for (int i = 0; i < MASK_N; i++)
            if (maskOff == 8'(i)) rdVal = vidMask[i];
        SEL_SADDR:
          for (int i = 0; i < SADDR_N; i++)
            if (saOff == 8'(i)) rdVal = smmAddr[i];
        default: rdVal = IDLE_DATA;
      endcase
    end
  end

endmodule

// File: rtl/cfg_idx_port.sv
module cfg_idx_port
  import cfg_idx_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0023,
  parameter logic [3:0]        ID0_LO    = 4'h1,
  parameter logic [7:0]        ID1_VAL   = 8'h25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [7:0]        ioWdata,
  input  logic              smmActive,
  output logic [7:0]        ioRdata,
  output logic              extCycle
);

  port_strb_t strb;
  logic       wideMap;
  logic       smmLock;

  cfg_idx_ctrl #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .smmActive(smmActive), .wideMap(wideMap),
    .smmLock(smmLock), .strb(strb), .extCycle(extCycle)
  );

  cfg_idx_regs #(
    .ID0_LO(ID0_LO), .ID1_VAL(ID1_VAL)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(ioWdata),
    .rdVal(ioRdata), .wideMap(wideMap), .smmLock(smmLock)
  );

endmodule

// File: rtl/cfg_idx_port_chk.sv
module cfg_idx_port_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0023
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioRd,
  input logic              ioWr,
  input logic [7:0]        ioRdata,
  input logic              extCycle,
  input logic              wideMap,
  input logic              smmLock,
  input logic              strbRd,
  input logic              strbWr,
  input logic [7:0]        strbIdx
);

  logic dataAcc;
  assign dataAcc = (ioAddr == DATA_PORT) && (ioRd || ioWr);

  p_fresh_index_r2: assert property (@(posedge clk) disable iff (!rstN)
    dataAcc |=> (!dataAcc || extCycle));

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    smmLock |=> smmLock);

  p_unclaimed_ff_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && extCycle) |-> (ioRdata == 8'hFF));

  p_claimed_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    strbRd |-> !extCycle);

  p_locked_write_claimed_r6: assert property (@(posedge clk) disable iff (!rstN)
    strbWr |-> !extCycle);

  p_quiet_elsewhere_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ioAddr != IDX_PORT && ioAddr != DATA_PORT) |-> !extCycle);

  p_base_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !extCycle && !wideMap) |-> (strbIdx[7:4] == 4'hC || strbIdx >= 8'hFE));

endmodule

bind cfg_idx_port cfg_idx_port_chk #(
  .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
  .ioRdata(ioRdata), .extCycle(extCycle), .wideMap(wideMap),
  .smmLock(smmLock), .strbRd(strb.rdEn), .strbWr(strb.wrEn),
  .strbIdx(strb.idx)
);

// File: tb/cfg_idx_port_test.sv
`timescale 1ns/1ps
module cfg_idx_port_test;

  localparam logic [15:0] P_IDX  = 16'h0022;
  localparam logic [15:0] P_DATA = 16'h0023;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_BRD = 2'd2, K_BWR = 2'd3;

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] idx;
    logic [7:0] data;
    logic       smm;
    logic [7:0] expRd;
    logic       expExt;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{K_WR,  8'hC2, 8'h5A, 1'b0, 8'h00, 1'b0, 4'd1},  // R1
    '{K_RD,  8'hC2, 8'h00, 1'b0, 8'h5A, 1'b0, 4'd1},  // R1
    '{K_BRD, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 4'd2},  // R2
    '{K_RD,  8'hE8, 8'h00, 1'b0, 8'hFF, 1'b1, 4'd3},  // R3
    '{K_RD,  8'hC0, 8'h00, 1'b0, 8'hFF, 1'b1, 4'd9},  // R9
    '{K_BRD, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 4'd2},  // R2 consumed by unclaimed
    '{K_RD,  8'hFE, 8'h00, 1'b0, 8'h41, 1'b0, 4'd5},  // R5
    '{K_WR,  8'hFE, 8'h00, 1'b0, 8'h00, 1'b0, 4'd8},  // R8
    '{K_RD,  8'hFE, 8'h00, 1'b0, 8'h41, 1'b0, 4'd8},  // R8
    '{K_WR,  8'hFF, 8'h00, 1'b0, 8'h00, 1'b0, 4'd8},  // R8
    '{K_RD,  8'hFF, 8'h00, 1'b0, 8'h25, 1'b0, 4'd8},  // R8
    '{K_WR,  8'hC3, 8'h10, 1'b0, 8'h00, 1'b0, 4'd4},  // R4
    '{K_RD,  8'hE8, 8'h00, 1'b0, 8'h85, 1'b0, 4'd5},  // R5
    '{K_RD,  8'h20, 8'h00, 1'b0, 8'h07, 1'b0, 4'd5},  // R5
    '{K_RD,  8'hB1, 8'h00, 1'b0, 8'h00, 1'b0, 4'd5},  // R5
    '{K_WR,  8'hB2, 8'h3C, 1'b0, 8'h00, 1'b0, 4'd4},  // R4
    '{K_RD,  8'hB2, 8'h00, 1'b0, 8'h3C, 1'b0, 4'd4},  // R4
    '{K_WR,  8'hBB, 8'h77, 1'b0, 8'h00, 1'b0, 4'd4},  // R4
    '{K_RD,  8'hBB, 8'h00, 1'b0, 8'h77, 1'b0, 4'd4},  // R4
    '{K_WR,  8'hEB, 8'hA5, 1'b0, 8'h00, 1'b0, 4'd4},  // R4
    '{K_RD,  8'hEB, 8'h00, 1'b0, 8'hA5, 1'b0, 4'd4},  // R4
    '{K_WR,  8'hB9, 8'hC4, 1'b0, 8'h00, 1'b0, 4'd4},  // R4
    '{K_RD,  8'hB9, 8'h00, 1'b0, 8'hC4, 1'b0, 4'd4},  // R4
    '{K_WR,  8'hCE, 8'h11, 1'b0, 8'h00, 1'b0, 4'd3},  // R3
    '{K_RD,  8'hCE, 8'h00, 1'b0, 8'h11, 1'b0, 4'd3},  // R3
    '{K_WR,  8'hC3, 8'h11, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 set lock
    '{K_RD,  8'hC3, 8'h00, 1'b0, 8'h11, 1'b0, 4'd6},  // R6
    '{K_WR,  8'hCE, 8'h99, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 claimed, ignored
    '{K_RD,  8'hCE, 8'h00, 1'b0, 8'h11, 1'b0, 4'd6},  // R6
    '{K_WR,  8'hC1, 8'h0F, 1'b0, 8'h00, 1'b0, 4'd6},  // R6
    '{K_RD,  8'hC1, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},  // R6
    '{K_WR,  8'hC1, 8'h0F, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 smm lifts lock
    '{K_RD,  8'hC1, 8'h00, 1'b0, 8'h0F, 1'b0, 4'd6},  // R6
    '{K_WR,  8'hC3, 8'h00, 1'b1, 8'h00, 1'b0, 4'd7},  // R7
    '{K_RD,  8'hC3, 8'h00, 1'b0, 8'h01, 1'b0, 4'd7},  // R7 lock stays
    '{K_RD,  8'hE8, 8'h00, 1'b0, 8'hFF, 1'b1, 4'd3},  // R3 wide map off again
    '{K_RD,  8'hB9, 8'h00, 1'b0, 8'hFF, 1'b1, 4'd3},  // R3
    '{K_WR,  8'hC2, 8'h66, 1'b0, 8'h00, 1'b0, 4'd2},  // R2
    '{K_BWR, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 bare write
    '{K_RD,  8'hC2, 8'h00, 1'b0, 8'h66, 1'b0, 4'd2},  // R2 unchanged
    '{K_RD,  8'hC5, 8'h00, 1'b0, 8'hFF, 1'b1, 4'd9},  // R9
    '{K_WR,  8'h12, 8'h44, 1'b0, 8'h00, 1'b1, 4'd9}   // R9
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioRd = 1'b0, ioWr = 1'b0, smmActive = 1'b0;
  logic [7:0]  ioWdata = '0;
  logic [7:0]  ioRdata;
  logic        extCycle;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;
  logic [7:0]  rd;
  logic        ext;

  always #4 clk = ~clk;

  cfg_idx_port uut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .smmActive(smmActive), .ioRdata(ioRdata),
    .extCycle(extCycle)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic r, input logic w,
                        input logic [7:0] d, input logic smm,
                        output logic [7:0] rdat, output logic e);
    @(posedge clk); #1;
    ioAddr = a; ioRd = r; ioWr = w; ioWdata = d; smmActive = smm;
    @(negedge clk);
    rdat = ioRdata; e = extCycle;
    @(posedge clk); #1;
    ioRd = 1'b0; ioWr = 1'b0; smmActive = 1'b0; ioAddr = 16'h0080;
  endtask

  task automatic idxRead(input logic [7:0] idx, input logic [7:0] exp,
                         input logic expExt, input string req);
    access(P_IDX, 1'b0, 1'b1, idx, 1'b0, rd, ext);
    access(P_DATA, 1'b1, 1'b0, 8'h00, 1'b0, rd, ext);
    chk({req, " data"}, rd, exp);
    chk({req, " ext"}, {7'b0, ext}, {7'b0, expExt});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R5 idle ext after reset", {7'b0, extCycle}, 8'h00);
    chk("R9 idle rdata after reset", ioRdata, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VECS[i].req, i);
      case (VECS[i].kind)
        K_WR: begin
          access(P_IDX, 1'b0, 1'b1, VECS[i].idx, 1'b0, rd, ext);
          chk({tag, " idx ext"}, {7'b0, ext}, 8'h00);
          access(P_DATA, 1'b0, 1'b1, VECS[i].data, VECS[i].smm, rd, ext);
          chk({tag, " ext"}, {7'b0, ext}, {7'b0, VECS[i].expExt});
        end
        K_RD: begin
          access(P_IDX, 1'b0, 1'b1, VECS[i].idx, 1'b0, rd, ext);
          access(P_DATA, 1'b1, 1'b0, 8'h00, VECS[i].smm, rd, ext);
          chk({tag, " data"}, rd, VECS[i].expRd);
          chk({tag, " ext"}, {7'b0, ext}, {7'b0, VECS[i].expExt});
        end
        K_BRD: begin
          access(P_DATA, 1'b1, 1'b0, 8'h00, VECS[i].smm, rd, ext);
          chk({tag, " data"}, rd, VECS[i].expRd);
          chk({tag, " ext"}, {7'b0, ext}, {7'b0, VECS[i].expExt});
        end
        default: begin
          access(P_DATA, 1'b0, 1'b1, VECS[i].data, VECS[i].smm, rd, ext);
          chk({tag, " ext"}, {7'b0, ext}, {7'b0, VECS[i].expExt});
        end
      endcase
    end

    // R10: index port read goes out, foreign addresses stay quiet
    access(P_IDX, 1'b1, 1'b0, 8'h00, 1'b0, rd, ext);
    chk("R10 index read ext", {7'b0, ext}, 8'h01);
    chk("R10 index read data", rd, 8'hFF);
    access(16'h0080, 1'b0, 1'b1, 8'h12, 1'b0, rd, ext);
    chk("R10 foreign write ext", {7'b0, ext}, 8'h00);
    access(16'h0024, 1'b1, 1'b0, 8'h00, 1'b0, rd, ext);
    chk("R10 foreign read ext", {7'b0, ext}, 8'h00);

    // R7 and R5: reset clears the lock and restores defaults
    @(posedge clk); #1 rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    idxRead(8'hC3, 8'h00, 1'b0, "R7 lock cleared by reset");
    idxRead(8'hC2, 8'h00, 1'b0, "R5 C2 reset");
    idxRead(8'hE8, 8'hFF, 1'b1, "R3 wide map reset");
    access(P_IDX, 1'b0, 1'b1, 8'hC3, 1'b0, rd, ext);
    access(P_DATA, 1'b0, 1'b1, 8'h10, 1'b0, rd, ext);
    idxRead(8'hB3, 8'h00, 1'b0, "R5 B3 reset");
    idxRead(8'hB8, 8'h00, 1'b0, "R5 B8 reset");
    idxRead(8'hEB, 8'h00, 1'b0, "R5 EB reset");
    idxRead(8'hCF, 8'h00, 1'b0, "R5 CF reset");
    idxRead(8'hE8, 8'h85, 1'b0, "R5 E8 reset");
    // R6: locked register stays writable from smm after reset sequence
    access(P_IDX, 1'b0, 1'b1, 8'hC3, 1'b0, rd, ext);
    access(P_DATA, 1'b0, 1'b1, 8'h11, 1'b0, rd, ext);
    access(P_IDX, 1'b0, 1'b1, 8'hCD, 1'b0, rd, ext);
    access(P_DATA, 1'b0, 1'b1, 8'h5C, 1'b1, rd, ext);
    chk("R6 smm write ext", {7'b0, ext}, 8'h00);
    idxRead(8'hCD, 8'h5C, 1'b0, "R6 smm write stored");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule